// File: doc/BRIEF.md
# Kicked Register Write Guard with Slow-Tick Busy Flag

This block guards a small bank of configuration registers in a low-speed timekeeping peripheral against stray writes. The protected registers always read back, but a write to them only lands once software has opened the guard. To open it, software writes one fixed 32-bit word to a first kick register and then a second fixed word to a second kick register. Writing zero to both kick registers, first then second, closes the guard again.

The block also reports when the slow timekeeping domain is updating. Each pulse on the 32.768 kHz tick input, already brought into the bus clock domain, raises a BUSY flag for a set number of bus clocks. When BUSY falls, a short safe-access window follows. A protected write is taken only when the guard is open and BUSY is low. BUSY, the open/closed state and the window can all be read from a status register. Reads have one cycle of latency.

Top module: `rtc_wguard`

## Requirements
- R1: After reset the guard is closed, BUSY and the window flag are low, every protected register holds zero, and `bus_rdata` is zero.
- R2: A write of 0x83E70B13 to the first kick register (offset 0x6C), followed by a write of 0x95A4F1E0 to the second kick register (offset 0x70), opens the guard. Status bit 1 reads 1 from the next cycle on.
- R3: While the first magic word is pending, two things send the guard back to closed: writing any other value to the first kick register, or writing any value other than the second magic word to the second kick register. A later write of the second magic word does not open it. From the closed state, one write can never open the guard.
- R4: With the guard open, writing 0 to the first kick register and then 0 to the second closes it. If the second write of that pair is nonzero, the guard stays open.
- R5: While the guard is closed, writes to the protected registers (word offsets 0x00, 0x04, 0x08, 0x0C) leave them unchanged.
- R6: While the guard is open and BUSY is low, a protected write takes effect and reads back on later reads. A protected write made while BUSY is high is dropped.
- R7: A tick pulse seen while BUSY is low raises BUSY on the next cycle, and BUSY stays high for exactly BUSY_CYC cycles. A tick that arrives while BUSY is high has no effect.
- R8: When BUSY falls, the window flag is high for exactly WIN_CYC cycles. It is never high together with BUSY. A tick during the window ends the window and starts BUSY.
- R9: The status register sits at offset 0x44, with bit 0 = BUSY, bit 1 = open, bit 2 = window, and all other bits zero. The kick registers and unmapped offsets read as zero. A read asserted in cycle N returns the state held before that cycle's write, in `bus_rdata` after the next edge. When no read is asserted, `bus_rdata` is zero.
- R10: The kick registers can be written whatever the guard state. Writes to the status register or to unmapped offsets change nothing that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| slow_tick | input | 1 | Single-cycle pulse per slow-clock update, synchronous to clk |

## Verification
The assertions assume three things about the inputs. `slow_tick` is already synchronous to `clk`. The address is word-aligned. The write data is stable while the write strobe is high. The stimulus drives every input on the falling edge. It sends the tick as isolated single-cycle pulses, and uses only aligned offsets, including unmapped ones. It sends ticks during BUSY and during the window, writes during BUSY, and both broken kick orders, so that the state-machine and timer assertions are exercised at their edges.

// File: rtl/rtc_wguard_pkg.sv
package rtc_wguard_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED  = 2'd0,
    KS_ARMED   = 2'd1,
    KS_OPEN    = 2'd2,
    KS_CLOSING = 2'd3
  } kick_st_e;

  localparam logic [31:0] MAGIC_FIRST  = 32'h83E7_0B13;
  localparam logic [31:0] MAGIC_SECOND = 32'h95A4_F1E0;
  localparam int unsigned OFS_STATUS = 32'h44;
  localparam int unsigned OFS_KICK_A = 32'h6C;
  localparam int unsigned OFS_KICK_B = 32'h70;
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_OPEN_BIT = 1;
  localparam int unsigned STAT_WIN_BIT  = 2;
endpackage

// File: rtl/wg_kick_fsm.sv
module wg_kick_fsm
  import rtc_wguard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick_a_wr,
  input  logic              kick_b_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  localparam logic [DATA_W-1:0] M_A = DATA_W'(MAGIC_FIRST);
  localparam logic [DATA_W-1:0] M_B = DATA_W'(MAGIC_SECOND);

  kick_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KS_LOCKED: begin
        if (kick_a_wr && wdata == M_A) st_d = KS_ARMED;
      end
      KS_ARMED: begin
        if (kick_a_wr && wdata != M_A) st_d = KS_LOCKED;
        else if (kick_b_wr) st_d = (wdata == M_B) ? KS_OPEN : KS_LOCKED;
      end
      KS_OPEN: begin
        if (kick_a_wr && wdata == '0) st_d = KS_CLOSING;
      end
      KS_CLOSING: begin
        if (kick_a_wr && wdata != '0) st_d = KS_OPEN;
        else if (kick_b_wr) st_d = (wdata == '0) ? KS_LOCKED : KS_OPEN;
      end
      default: st_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_LOCKED;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == KS_OPEN) || (st_q == KS_CLOSING);

  // R3: no single write opens the guard from the closed state
  assert_no_direct_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KS_LOCKED) |=> (st_q != KS_OPEN));

  // R2: the open state is entered only through the second magic word
  assert_open_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KS_OPEN && $past(st_q) != KS_OPEN && $past(st_q) != KS_CLOSING)
      |-> ($past(st_q) == KS_ARMED && $past(kick_b_wr) && $past(wdata) == M_B));

  // R4: zero pair completes the close
  assert_close_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == KS_LOCKED && $past(st_q) == KS_CLOSING) |-> ($past(wdata) == '0));
endmodule

// File: rtl/wg_slow_timer.sv
module wg_slow_timer #(
  parameter int BUSY_CYC = 8,
  parameter int WIN_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic busy,
  output logic win
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam int WW = $clog2(WIN_CYC + 1) < 1 ? 1 : $clog2(WIN_CYC + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYC);
  localparam logic [WW-1:0] WIN_LOAD  = WW'(WIN_CYC);

  logic [BW-1:0] busy_q, busy_d;
  logic [WW-1:0] win_q, win_d;
  logic          cnt_en;

  always_comb begin
    busy_d = busy_q;
    win_d  = win_q;
    if (tick && busy_q == '0) begin
      busy_d = BUSY_LOAD;
      win_d  = '0;
    end else if (busy_q != '0) begin
      busy_d = busy_q - 1'b1;
      win_d  = (busy_q == BW'(1)) ? WIN_LOAD : '0;
    end else if (win_q != '0) begin
      win_d = win_q - 1'b1;
    end
  end

  assign cnt_en = tick || (busy_q != '0) || (win_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      win_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      win_q  <= win_d;
    end
  end

  assign busy = (busy_q != '0);
  assign win  = (win_q != '0);

  // R7: an idle tick raises BUSY on the following cycle
  assert_tick_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !busy) |=> busy);

  // R8: window and BUSY exclusive
  assert_win_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && win));

  generate
    if (WIN_CYC > 0) begin : g_win_chk
      // R8: falling BUSY opens the window
      assert_win_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> win);
    end
  endgenerate
endmodule

// File: rtl/wg_regfile.sv
module wg_regfile #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr,
  input  logic                            wr_allow,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0] mem_q
);
  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic hit;
      assign hit = wr && wr_allow && (addr == ADDR_W'(i * 4));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem_q[i] <= '0;
        else if (hit) mem_q[i] <= wdata;
      end
    end
  endgenerate

  // R5 / R6: without permission the register bank holds its value
  assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |=> $stable(mem_q));
endmodule

// File: rtl/rtc_wguard.sv
module rtc_wguard
  import rtc_wguard_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int BUSY_CYC = 8,
  parameter int WIN_CYC  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        slow_tick
);
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_KA   = ADDR_W'(OFS_KICK_A);
  localparam logic [ADDR_W-1:0] A_KB   = ADDR_W'(OFS_KICK_B);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic kick_a_wr, kick_b_wr, unlocked, busy, win;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  assign kick_a_wr = bus_wr && (bus_addr == A_KA);
  assign kick_b_wr = bus_wr && (bus_addr == A_KB);

  wg_kick_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .kick_a_wr(kick_a_wr), .kick_b_wr(kick_b_wr),
    .wdata(bus_wdata), .unlocked(unlocked)
  );

  wg_slow_timer #(.BUSY_CYC(BUSY_CYC), .WIN_CYC(WIN_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .tick(slow_tick), .busy(busy), .win(win)
  );

  wg_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst_n(rst_i_n), .wr(bus_wr), .wr_allow(unlocked && !busy),
    .addr(bus_addr), .wdata(bus_wdata), .mem_q(regs)
  );

  logic [DATA_W-1:0] rd_val, rdata_q;

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_STAT) begin
      rd_val[STAT_BUSY_BIT] = busy;
      rd_val[STAT_OPEN_BIT] = unlocked;
      rd_val[STAT_WIN_BIT]  = win;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (bus_addr == ADDR_W'(i * 4)) rd_val = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rdata_q <= '0;
    else          rdata_q <= bus_rd ? rd_val : '0;
  end
  assign bus_rdata = rdata_q;

  // R9: idle bus returns zero data
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/rtc_wguard_tb_top.sv
module rtc_wguard_tb_top;
  localparam int NREG = 4;
  localparam int BCYC = 8;
  localparam int WCYC = 4;
  localparam logic [31:0] MA = 32'h83E70B13;
  localparam logic [31:0] MB = 32'h95A4F1E0;
  localparam logic [7:0] ST = 8'h44, KA = 8'h6C, KB = 8'h70;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, slow_tick = 1'b0;
  logic [31:0] bus_rdata;

  always #4 clk = ~clk;

  rtc_wguard #(.NUM_REGS(NREG), .BUSY_CYC(BCYC), .WIN_CYC(WCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .slow_tick(slow_tick)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit chk_on = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_st, m_busy, m_win;
  logic [31:0] m_regs [NREG];
  logic [31:0] exp_rd;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == ST) return {29'd0, m_win > 0, m_st >= 2, m_busy > 0};
    if (a[1:0] == 2'b00 && int'(a[7:2]) < NREG) return m_regs[a[7:2]];
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_busy = 0; m_win = 0; exp_rd = 0;
      foreach (m_regs[i]) m_regs[i] = 0;
    end else begin
      bit ok;
      exp_rd = bus_rd ? m_read(bus_addr) : 32'd0;
      ok = (m_st >= 2) && (m_busy == 0);
      if (bus_wr) begin
        if (bus_addr == KA) begin
          if (m_st == 0 && bus_wdata == MA) m_st = 1;
          else if (m_st == 1 && bus_wdata != MA) m_st = 0;
          else if (m_st == 2 && bus_wdata == 0) m_st = 3;
          else if (m_st == 3 && bus_wdata != 0) m_st = 2;
        end else if (bus_addr == KB) begin
          if (m_st == 1) m_st = (bus_wdata == MB) ? 2 : 0;
          else if (m_st == 3) m_st = (bus_wdata == 0) ? 0 : 2;
        end else if (ok && bus_addr[1:0] == 0 && int'(bus_addr[7:2]) < NREG)
          m_regs[bus_addr[7:2]] = bus_wdata;
      end
      if (slow_tick && m_busy == 0) begin m_busy = BCYC; m_win = 0; end
      else if (m_busy > 0) begin m_busy--; if (m_busy == 0) m_win = WCYC; end
      else if (m_win > 0) m_win--;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (chk_on) begin
      n_cmp++;
      if (bus_rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL %s: bus_rdata actual %h expected %h at cycle %0d",
                 cur_req, bus_rdata, exp_rd, cyc);
      end
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic op(input logic w, input logic r, input logic [7:0] a,
                    input logic [31:0] d, input logic t);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; slow_tick = t;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; slow_tick = 0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); op(1, 0, a, d, 0); endtask
  task automatic rd(input logic [7:0] a); op(0, 1, a, 32'd0, 0); endtask
  task automatic tick(); op(0, 1, ST, 32'd0, 1); endtask
  task automatic idle_st(input int n);
    for (int i = 0; i < n; i++) rd(ST);
  endtask
  task automatic unlock(); wr(KA, MA); wr(KB, MB); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_on = 1;
    // R1 reset state
    cur_req = "R1"; rd(ST); rd(8'h00); rd(8'h0C); op(0, 0, 8'h00, 0, 0);
    // R5 writes while closed
    cur_req = "R5"; wr(8'h00, 32'hDEAD_0001); wr(8'h08, 32'h1234); rd(8'h00); rd(8'h08);
    // R2 unlock
    cur_req = "R2"; unlock(); rd(ST);
    // R6 write while open
    cur_req = "R6"; wr(8'h04, 32'hCAFE_F00D); rd(8'h04); wr(8'h0C, 32'h5A5A); rd(8'h0C);
    // R7 busy timing, R6 write during busy dropped
    cur_req = "R7"; tick(); idle_st(2);
    cur_req = "R6"; wr(8'h04, 32'h0BAD_0BAD); rd(8'h04);
    cur_req = "R7"; tick(); idle_st(3);
    // R8 window and tick inside window
    cur_req = "R8"; idle_st(3); tick(); idle_st(BCYC + WCYC + 2);
    cur_req = "R6"; wr(8'h04, 32'h600D); rd(8'h04);
    // R4 aborted close, then real close
    cur_req = "R4"; wr(KA, 0); wr(KB, 32'h5); rd(ST);
    wr(KA, 0); wr(KA, 32'h7); rd(ST);
    wr(KA, 0); wr(KB, 0); rd(ST);
    cur_req = "R5"; wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
    // R3 wrong orders
    cur_req = "R3"; wr(KA, 32'h1); wr(KB, MB); rd(ST);
    wr(KA, MA); wr(KB, 32'h2); wr(KB, MB); rd(ST);
    wr(KA, MA); wr(KA, MB); wr(KB, MB); rd(ST);
    wr(KB, MB); rd(ST);
    wr(KA, MA); wr(8'h00, 32'h77); wr(KB, MB); rd(ST); rd(8'h00);
    // R9 / R10 read map and ignored writes
    cur_req = "R9"; rd(KA); rd(KB); rd(8'h10); rd(8'h40);
    cur_req = "R10"; wr(ST, 32'hFFFF_FFFF); rd(ST); wr(8'h20, 32'h9); rd(8'h20);
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
    cur_req = "R10"; wr(KA, 0); wr(KB, 0); rd(ST); wr(KB, 0); rd(ST);
    idle_st(2);
    chk_on = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule